// File: doc/BRIEF.md
# Prefetch Engine Register File

This block holds the software-visible control for a NAND prefetch and postwrite engine. It stores the engine's setup word and the byte count of the next transfer, and it owns the started/stopped state. It packs the engine's live FIFO pointer and remaining count into a read-only status word. It also keeps a two-source interrupt status with an enable mask and drives a single interrupt line.

A host reaches it through a simple word-wide port. Writes take effect on the clock edge. Reads are combinational and have no side effects.

The engine datapath sits beside it. It reads the decoded setup fields and the start level from this block. In return it reports its FIFO pointer and remaining count every cycle, and it raises a one-cycle pulse when the terminal count is reached.

Top module: `prefetch_regfile`

## Requirements
- R1: The register offsets are setup 0x00, transfer count 0x04, control 0x08, status 0x0C, interrupt status 0x10 and interrupt enable 0x14. A read of any other offset returns zero. A write to any other offset changes no register and no output.
- R2: A setup write stores the data ANDed with 0x7F8F7FBF, and the register resets to 0x00004000. The outputs decode it as follows: bit 0 is write mode, bit 2 is DMA enable, bit 7 is engine enable, bits 14:8 are the 7-bit threshold and bits 26:24 are the 3-bit chip select. A read returns the stored word.
- R3: The transfer count register is 14 bits wide and is read back in bits 13:0. A write to the setup register or the transfer count register is ignored while the engine is started.
- R4: Control bit 0 is the started state, which drives `engStart` and reads back in bit 0. A control write acts only when its bit 0 differs from the current state. A terminal-count pulse clears the started state, unless a control write changes that state in the same cycle.
- R5: The status word carries the FIFO pointer in bits 30:24, a threshold flag in bit 16 and the remaining count in bits 13:0. All other bits read as zero.
- R6: The status threshold flag is 1 exactly when the FIFO pointer is greater than or equal to the threshold.
- R7: Interrupt status bit 0 is set on every clock edge at which the pointer is at or above the threshold. Setting takes priority over a clear in the same cycle.
- R8: A terminal-count pulse sets interrupt status bit 1 on the next edge.
- R9: Writing to interrupt status clears each bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R10: Interrupt enable is 2 bits wide and reads back in bits 1:0. On each edge `irqOut` takes the OR of (enable AND status) as those registers stood before that edge, and it changes only when that masked value changes.
- R11: Reset, active-low and synchronous, clears the interrupt status, the interrupt enable, the started state, the transfer count and `irqOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte offset of the register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| engPtr | input | PTR_W | Engine FIFO pointer |
| engCount | input | CNT_W | Engine remaining byte count |
| engTermPulse | input | 1 | One-cycle terminal-count event |
| engStart | output | 1 | Started state |
| cfgWriteMode | output | 1 | Setup: postwrite direction |
| cfgDmaEn | output | 1 | Setup: DMA request enable |
| cfgEngineEn | output | 1 | Setup: engine enable |
| cfgThreshold | output | 7 | Setup: FIFO threshold |
| cfgChipSel | output | 3 | Setup: chip select |
| xferCount | output | CNT_W | Programmed transfer count |
| irqOut | output | 1 | Interrupt line |

## Verification
A corrupted setup or transfer-count register shows up on the decoded outputs one edge after the bad write. If a write slips past the lock, the setup outputs move while `engStart` is high. A wrong started state shows directly on `engStart`, and a terminal pulse that fails to stop the engine is visible on the next edge. A wrong interrupt status bit appears on the interrupt status read one edge after the cause. It reaches `irqOut` one edge later still, so the line carries a two-edge lag behind a pointer or pulse event, and a stuck clear is visible as a status bit that survives a write of ones while its source is idle.

// File: rtl/pf_regs_pkg.sv
package pf_regs_pkg;
  localparam int DATA_W = 32;
  localparam int THR_W  = 7;
  localparam int CS_W   = 3;
  localparam int IRQ_N  = 2;

  localparam int OFF_CFG    = 'h00;
  localparam int OFF_XFER   = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int OFF_STATUS = 'h0C;
  localparam int OFF_IRQST  = 'h10;
  localparam int OFF_IRQEN  = 'h14;

  localparam logic [DATA_W-1:0] CFG_MASK  = 32'h7F8F_7FBF;
  localparam logic [DATA_W-1:0] CFG_RESET = 32'h0000_4000;

  // Setup field positions (decoded by the engine)
  localparam int CFG_WMODE_BIT = 0;
  localparam int CFG_DMA_BIT   = 2;
  localparam int CFG_EN_BIT    = 7;
  localparam int CFG_THR_LSB   = 8;
  localparam int CFG_CS_LSB    = 24;

  // Status word packing
  localparam int ST_PTR_LSB  = 24;
  localparam int ST_FLAG_BIT = 16;

  typedef struct packed {
    logic              cfgWr;
    logic              xferWr;
    logic              irqClr;
    logic              irqEnWr;
    logic [DATA_W-1:0] data;
  } pfStrobes_t;
endpackage

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pf_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              termPulse,
  output pfStrobes_t        strb,
  output logic              started
);
  logic ctrlHit;
  logic ctrlToggle;

  assign ctrlHit    = regWrEn && (int'(regAddr) == OFF_CTRL);
  assign ctrlToggle = ctrlHit && (regWrData[0] != started);

  always_comb begin
    strb.cfgWr   = regWrEn && (int'(regAddr) == OFF_CFG)  && !started;
    strb.xferWr  = regWrEn && (int'(regAddr) == OFF_XFER) && !started;
    strb.irqClr  = regWrEn && (int'(regAddr) == OFF_IRQST);
    strb.irqEnWr = regWrEn && (int'(regAddr) == OFF_IRQEN);
    strb.data    = regWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           started <= 1'b0;
    else if (ctrlToggle) started <= regWrData[0];
    else if (termPulse)  started <= 1'b0;
  end
endmodule

// File: rtl/pf_regs.sv
module pf_regs
  import pf_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 7,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfStrobes_t        strb,
  input  logic              started,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PTR_W-1:0]  engPtr,
  input  logic [CNT_W-1:0]  engCount,
  input  logic              termPulse,
  output logic              cfgWriteMode,
  output logic              cfgDmaEn,
  output logic              cfgEngineEn,
  output logic [THR_W-1:0]  cfgThreshold,
  output logic [CS_W-1:0]   cfgChipSel,
  output logic [CNT_W-1:0]  xferCount,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  logic [DATA_W-1:0] cfgReg;
  logic [CNT_W-1:0]  xferReg;
  logic [IRQ_N-1:0]  irqSt, irqEn, lastIrq, irqSet, irqMasked;
  logic              thrHit;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (!rstN)           cfgReg <= CFG_RESET;
    else if (strb.cfgWr) cfgReg <= strb.data & CFG_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            xferReg <= '0;
    else if (strb.xferWr) xferReg <= strb.data[CNT_W-1:0];
  end

  assign cfgWriteMode = cfgReg[CFG_WMODE_BIT];
  assign cfgDmaEn     = cfgReg[CFG_DMA_BIT];
  assign cfgEngineEn  = cfgReg[CFG_EN_BIT];
  assign cfgThreshold = cfgReg[CFG_THR_LSB +: THR_W];
  assign cfgChipSel   = cfgReg[CFG_CS_LSB +: CS_W];
  assign xferCount    = xferReg;

  assign thrHit = ({1'b0, engPtr} >= (PTR_W+1)'(cfgThreshold));
  assign irqSet = {termPulse, thrHit};

  // One status bit per interrupt source: set beats clear
  for (genvar i = 0; i < IRQ_N; i++) begin : g_irqBit
    always_ff @(posedge clk) begin
      if (!rstN)                            irqSt[i] <= 1'b0;
      else if (irqSet[i])                   irqSt[i] <= 1'b1;
      else if (strb.irqClr && strb.data[i]) irqSt[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             irqEn <= '0;
    else if (strb.irqEnWr) irqEn <= strb.data[IRQ_N-1:0];
  end

  assign irqMasked = irqEn & irqSt;

  // The line follows the masked vector and moves only when that vector differs
  always_ff @(posedge clk) begin
    if (!rstN)                       lastIrq <= '0;
    else if (irqMasked != lastIrq)   lastIrq <= irqMasked;
  end
  assign irqOut = |lastIrq;

  always_comb begin
    statusWord = '0;
    statusWord[ST_PTR_LSB +: PTR_W] = engPtr;
    statusWord[ST_FLAG_BIT]         = thrHit;
    statusWord[CNT_W-1:0]           = engCount;
  end

  always_comb begin
    regRdData = '0;
    case (int'(regAddr))
      OFF_CFG:    regRdData = cfgReg;
      OFF_XFER:   regRdData[CNT_W-1:0] = xferReg;
      OFF_CTRL:   regRdData[0] = started;
      OFF_STATUS: regRdData = statusWord;
      OFF_IRQST:  regRdData[IRQ_N-1:0] = irqSt;
      OFF_IRQEN:  regRdData[IRQ_N-1:0] = irqEn;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/prefetch_regfile.sv
module prefetch_regfile
  import pf_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 7,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [PTR_W-1:0]  engPtr,
  input  logic [CNT_W-1:0]  engCount,
  input  logic              engTermPulse,
  output logic              engStart,
  output logic              cfgWriteMode,
  output logic              cfgDmaEn,
  output logic              cfgEngineEn,
  output logic [6:0]        cfgThreshold,
  output logic [2:0]        cfgChipSel,
  output logic [CNT_W-1:0]  xferCount,
  output logic              irqOut
);
  pfStrobes_t strb;
  logic       started;

  pf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .termPulse(engTermPulse),
    .strb(strb), .started(started)
  );

  pf_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .started(started),
    .regAddr(regAddr), .engPtr(engPtr), .engCount(engCount),
    .termPulse(engTermPulse),
    .cfgWriteMode(cfgWriteMode), .cfgDmaEn(cfgDmaEn),
    .cfgEngineEn(cfgEngineEn), .cfgThreshold(cfgThreshold),
    .cfgChipSel(cfgChipSel), .xferCount(xferCount),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  assign engStart = started;
endmodule

// File: rtl/pf_regs_chk.sv
module pf_regs_chk
  import pf_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 7,
  parameter int CNT_W  = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [31:0]       regRdData,
  input logic [PTR_W-1:0]  engPtr,
  input logic              engTermPulse,
  input logic              engStart,
  input logic              cfgWriteMode,
  input logic              cfgDmaEn,
  input logic              cfgEngineEn,
  input logic [6:0]        cfgThreshold,
  input logic [2:0]        cfgChipSel,
  input logic [CNT_W-1:0]  xferCount,
  input logic              irqOut
);
  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && regWrEn && int'(regAddr) == OFF_CFG) |=>
      $stable({cfgWriteMode, cfgDmaEn, cfgEngineEn, cfgThreshold, cfgChipSel}));

  a_r3_xfer_locked: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && regWrEn && int'(regAddr) == OFF_XFER) |=> $stable(xferCount));

  a_r4_start_holds: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && !engTermPulse &&
     !(regWrEn && int'(regAddr) == OFF_CTRL && !regWrData[0])) |=> engStart);

  a_r4_start_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(engStart) |-> $past(regWrEn && int'(regAddr) == OFF_CTRL && regWrData[0]));

  a_r7_thr_sets: assert property (@(posedge clk) disable iff (!rstN)
    ($past(engPtr >= PTR_W'(cfgThreshold)) && int'(regAddr) == OFF_IRQST) |-> regRdData[0]);

  a_r8_term_sets: assert property (@(posedge clk) disable iff (!rstN)
    ($past(engTermPulse) && int'(regAddr) == OFF_IRQST) |-> regRdData[1]);

  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($past(regWrEn && int'(regAddr) == OFF_IRQEN && regWrData[1:0] == 2'b00) &&
     !(regWrEn && int'(regAddr) == OFF_IRQEN)) |=> !irqOut);

  a_r11_reset_state: assert property (@(posedge clk)
    !rstN |=> (!engStart && !irqOut && xferCount == '0));
endmodule

bind prefetch_regfile pf_regs_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .engPtr(engPtr),
  .engTermPulse(engTermPulse), .engStart(engStart),
  .cfgWriteMode(cfgWriteMode), .cfgDmaEn(cfgDmaEn), .cfgEngineEn(cfgEngineEn),
  .cfgThreshold(cfgThreshold), .cfgChipSel(cfgChipSel),
  .xferCount(xferCount), .irqOut(irqOut)
);

// File: tb/tb_prefetch_regfile.sv
`timescale 1ns/1ps
module tb_prefetch_regfile;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [7:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [6:0]  engPtr;
  logic [13:0] engCount;
  logic        engTermPulse;
  logic        engStart, cfgWriteMode, cfgDmaEn, cfgEngineEn, irqOut;
  logic [6:0]  cfgThreshold;
  logic [2:0]  cfgChipSel;
  logic [13:0] xferCount;

  int checks = 0;
  int fails  = 0;

  // Bench model state
  logic [31:0] mCfg;
  logic [13:0] mXfer;
  logic        mStart;
  logic [1:0]  mSt, mEn, mLast;

  always #2.5 clk = ~clk;

  prefetch_regfile dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .engPtr(engPtr),
    .engCount(engCount), .engTermPulse(engTermPulse), .engStart(engStart),
    .cfgWriteMode(cfgWriteMode), .cfgDmaEn(cfgDmaEn), .cfgEngineEn(cfgEngineEn),
    .cfgThreshold(cfgThreshold), .cfgChipSel(cfgChipSel),
    .xferCount(xferCount), .irqOut(irqOut)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdModel(int a, logic [6:0] p, logic [13:0] c);
    logic flag;
    flag = (p >= mCfg[14:8]);
    case (a)
      'h00: return mCfg;
      'h04: return {18'b0, mXfer};
      'h08: return {31'b0, mStart};
      'h0C: return {1'b0, p, 7'b0, flag, 2'b0, c};
      'h10: return {30'b0, mSt};
      'h14: return {30'b0, mEn};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(int a);
    case (a)
      'h00: return "R2";
      'h04: return "R3";
      'h08: return "R4";
      'h0C: return "R5";
      'h10: return "R7";
      'h14: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic checkOutputs();
    chk("R2 fields", {20'b0, cfgChipSel, cfgThreshold, cfgEngineEn, cfgDmaEn, cfgWriteMode},
        {20'b0, mCfg[26:24], mCfg[14:8], mCfg[7], mCfg[2], mCfg[0]});
    chk("R3 xferCount", {18'b0, xferCount}, {18'b0, mXfer});
    chk("R4 engStart", {31'b0, engStart}, {31'b0, mStart});
    chk("R10 irqOut", {31'b0, irqOut}, {31'b0, |mLast});
  endtask

  // Drive one cycle of stimulus at a falling edge and check everything
  task automatic step(bit we, int a, logic [31:0] d, logic [6:0] p, logic [13:0] c, bit t);
    logic [31:0] nCfg;
    logic [13:0] nXfer;
    logic        nStart;
    logic [1:0]  nSt, nEn, nLast, clr;
    regWrEn = we; regAddr = a[7:0]; regWrData = d;
    engPtr = p; engCount = c; engTermPulse = t;
    #1;
    chk(tagFor(a), regRdData, rdModel(a, p, c));
    if (a == 'h0C) chk("R6 flag", {31'b0, regRdData[16]}, {31'b0, (p >= mCfg[14:8])});
    nStart = mStart;
    if (we && a == 'h08 && d[0] != mStart) nStart = d[0];
    else if (t) nStart = 1'b0;
    nCfg  = (we && a == 'h00 && !mStart) ? (d & 32'h7F8F_7FBF) : mCfg;
    nXfer = (we && a == 'h04 && !mStart) ? d[13:0] : mXfer;
    clr   = (we && a == 'h10) ? d[1:0] : 2'b00;
    nSt   = (mSt & ~clr) | {t, (p >= mCfg[14:8])};
    nEn   = (we && a == 'h14) ? d[1:0] : mEn;
    nLast = mEn & mSt;
    @(posedge clk);
    @(negedge clk);
    mCfg = nCfg; mXfer = nXfer; mStart = nStart;
    mSt = nSt; mEn = nEn; mLast = nLast;
    checkOutputs();
  endtask

  task automatic idle(int a, logic [6:0] p);
    step(1'b0, a, 32'h0, p, 14'h0, 1'b0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    rstN = 1'b0; regWrEn = 0; regAddr = 0; regWrData = 0;
    engPtr = 0; engCount = 0; engTermPulse = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mCfg = 32'h0000_4000; mXfer = 0; mStart = 0; mSt = 0; mEn = 0; mLast = 0;
    // R11: reset values
    #1;
    chk("R11 irqOut", {31'b0, irqOut}, 32'h0);
    chk("R11 engStart", {31'b0, engStart}, 32'h0);
    chk("R11 xferCount", {18'b0, xferCount}, 32'h0);
    regAddr = 8'h00; #0.5;
    chk("R11 setup", regRdData, 32'h0000_4000);
    @(negedge clk);

    // R2: write mask
    step(1'b1, 'h00, 32'hFFFF_FFFF, 7'd0, 14'd0, 1'b0);
    chk("R2 masked", {1'b0, cfgThreshold, cfgChipSel, cfgEngineEn, cfgDmaEn, cfgWriteMode}, {1'b0, 7'h7F, 3'h7, 1'b1, 1'b1, 1'b1});
    idle('h00, 7'd0);
    // threshold 10
    step(1'b1, 'h00, 32'h0000_0A00, 7'd0, 14'd0, 1'b0);
    // R6: boundary around threshold
    idle('h0C, 7'd9);
    idle('h0C, 7'd10);
    idle('h0C, 7'd11);
    // R1: undefined offset write/read
    step(1'b1, 'h18, 32'hFFFF_FFFF, 7'd0, 14'd5, 1'b0);
    idle('h18, 7'd0);
    idle('h00, 7'd0);
    // R9: clear status with pointer below threshold
    step(1'b1, 'h10, 32'h0000_0003, 7'd0, 14'd0, 1'b0);
    idle('h10, 7'd0);
    chk("R9 cleared", regRdData, 32'h0);
    // R7: clear while above threshold keeps bit 0
    step(1'b1, 'h10, 32'h0000_0001, 7'd20, 14'd0, 1'b0);
    idle('h10, 7'd0);
    chk("R7 set beats clear", regRdData, 32'h1);
    // R3/R4: start, locked writes, redundant start, terminal stop
    step(1'b1, 'h04, 32'h0000_FFFF, 7'd0, 14'd0, 1'b0);
    step(1'b1, 'h08, 32'h1, 7'd0, 14'd0, 1'b0);
    step(1'b1, 'h00, 32'h0000_0080, 7'd0, 14'd0, 1'b0);
    chk("R3 cfg locked", {25'b0, cfgThreshold}, 32'd10);
    step(1'b1, 'h04, 32'h0000_0001, 7'd0, 14'd0, 1'b0);
    chk("R3 xfer locked", {18'b0, xferCount}, 32'h3FFF);
    step(1'b1, 'h08, 32'h1, 7'd0, 14'd0, 1'b0);
    chk("R4 repeat start", {31'b0, engStart}, 32'h1);
    // R8: terminal pulse
    step(1'b1, 'h14, 32'h2, 7'd0, 14'd0, 1'b1);
    chk("R4 term stops", {31'b0, engStart}, 32'h0);
    idle('h10, 7'd0);
    chk("R8 term status", regRdData & 32'h2, 32'h2);
    idle('h10, 7'd0);
    chk("R10 irq raised", {31'b0, irqOut}, 32'h1);

    // Constrained random
    for (int i = 0; i < 4000; i++) begin
      int a;
      logic [31:0] d;
      case ($urandom_range(0, 9))
        0: a = 'h00; 1: a = 'h04; 2: a = 'h08; 3: a = 'h0C; 4: a = 'h10;
        5: a = 'h14; 6: a = 'h18; 7: a = 'h1C; 8: a = 'h3C; default: a = 'h08;
      endcase
      d = $urandom();
      if (a == 'h00) d[14:8] = 7'($urandom_range(0, 70));
      step(($urandom_range(0, 1) == 1), a, d, 7'($urandom_range(0, 64)),
           14'($urandom()), ($urandom_range(0, 15) == 0));
    end
    summary();
    $finish;
  end
endmodule